// File: doc/BRIEF.md
# DMA Channel Descriptor Sequencer

This block is one DMA channel. It walks through transfer descriptors kept in a small local descriptor store and turns each one into a stream of element reads and writes on a simple 32-bit memory bus. A descriptor is one of three kinds: a single element, a row of elements, or a grid of rows. It also sets the width of the data element, sets whether the source read and the destination write use the element width or a full 32-bit access, and points to the descriptor that follows it.

How much work one trigger starts is set per descriptor. It can be one element, one row, the whole descriptor, or the descriptor followed by its successors with no further trigger. One trigger that arrives while the channel is working is held and served afterwards. The channel switches itself off when a chain ends, when a descriptor asks for it, or when a descriptor is malformed.

The bus returns read data on the cycle after `rd_req`, in the low bits of `rd_data`. Write data is placed in the low bits of `wr_data`. A size code of 0, 1 or 2 means an 8-, 16- or 32-bit access.

Top module: `dma_desc_seq`

## Requirements
- R1: A `ch_start` pulse while the channel is idle sets `ch_en`, loads the descriptor pointer from `ch_start_ptr` and clears `err`. `ch_en` rises for no other reason.
- R2: While `ch_en` is low, `trig_in` starts no work and is not remembered. Enabling the channel later produces no transfer until a new trigger arrives.
- R3: Trigger mode 0 (control bits [21:20] = 0) moves exactly one element per trigger.
- R4: Trigger mode 1 moves one row per trigger. For a single-kind descriptor, a row is one element.
- R5: Trigger mode 2 moves every element of the current descriptor on one trigger.
- R6: Trigger mode 3 runs the current descriptor. It then loads and runs the next descriptor with no new trigger, and the mode of that next descriptor decides whether the run continues.
- R7: A trigger that arrives while `busy` is high is held as one pending request. This includes a trigger in the cycle that the current unit finishes. Any number of such triggers adds exactly one more unit of work.
- R8: Descriptor layout, by word:
  - word 0: control, with kind in [31:30] (0 single, 1 row, 2 grid).
  - word 1: source base.
  - word 2: destination base.
  - single kind: next pointer in word 3.
  - row and grid kinds: word 3 is the row word, with last index in [7:0], signed source step in [15:8] and signed destination step in [23:16].
  - grid kind: word 4 is a column word in the same format.
  - next pointer: word 4 for the row kind, word 5 for the grid kind.

  Element (x,y) is read at source base + x·row step + y·column step and written at the matching destination address. Every element is a read followed on the next cycle by a write.
- R9: The element size is in control [29:28] (0 = 8-bit, 1 = 16-bit, 2 = 32-bit). Control bit [26] widens the source access and bit [27] widens the destination access to 32 bits, and otherwise each access uses the element size. Read data above the element width is dropped, and write data above it is zero.
- R10: An element size of 3 or a descriptor kind of 3 sets `err` and clears `ch_en`, and no bus access is made.
- R11: `desc_done` pulses for one cycle per finished descriptor. `ch_en` is then cleared if control bit [24] is set, even when the next pointer is non-zero, or if the next pointer is zero.
- R12: `busy` goes high in the cycle after a trigger is accepted. It stays high until the selected unit of work has finished, and then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe into the descriptor store |
| cfg_wr_idx | input | PTR_W | Word index into the descriptor store |
| cfg_wr_data | input | 32 | Word written into the descriptor store |
| ch_start | input | 1 | Enables the channel (honoured when idle) |
| ch_start_ptr | input | PTR_W | First descriptor's word index |
| trig_in | input | 1 | Trigger input |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_size | output | 2 | Read access size code |
| rd_data | input | 32 | Read data, valid the cycle after rd_req |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_size | output | 2 | Write access size code |
| wr_data | output | 32 | Write data, zero above the element width |
| ch_en | output | 1 | Channel enabled |
| busy | output | 1 | A unit of work is in progress |
| desc_done | output | 1 | One-cycle pulse per finished descriptor |
| err | output | 1 | Malformed descriptor seen; cleared by ch_start |

## Verification
The case that needs the most care is a new trigger that lands in the same cycle the current unit of work finishes with its element write. In that cycle the channel has not yet gone idle, so the trigger must go to the pending flag and not be lost. The bench provokes this by watching for `wr_req` and raising `trig_in` for exactly that cycle. It then expects exactly one further element at the next computed address. It also holds the trigger high over several busy cycles and expects exactly one extra unit, not one per cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int WORD_W     = 32;
  localparam int IDX_W      = 8;
  localparam int DESC_WORDS = 6;

  typedef enum logic [1:0] {
    DK_SINGLE = 2'd0,
    DK_ROW    = 2'd1,
    DK_GRID   = 2'd2,
    DK_BAD    = 2'd3
  } desc_kind_e;

  typedef enum logic [1:0] {
    TM_ELEM  = 2'd0,
    TM_ROW   = 2'd1,
    TM_DESC  = 2'd2,
    TM_CHAIN = 2'd3
  } trig_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_RD,
    S_WR,
    S_DONE
  } seq_state_e;

  typedef struct packed {
    logic [1:0]        esize;
    logic              dst_wide;
    logic              src_wide;
    logic              stop_after;
    trig_mode_e        tmode;
    logic [WORD_W-1:0] src_base;
    logic [WORD_W-1:0] dst_base;
    logic [IDX_W-1:0]  xlast;
    logic [IDX_W-1:0]  sxstep;
    logic [IDX_W-1:0]  dxstep;
    logic [IDX_W-1:0]  ylast;
    logic [IDX_W-1:0]  systep;
    logic [IDX_W-1:0]  dystep;
    logic [WORD_W-1:0] next_ptr;
  } desc_t;

  // byte address of element (x,y): base + x*xstep + y*ystep, steps signed
  function automatic logic [WORD_W-1:0] elem_addr(
      input logic [WORD_W-1:0] base,
      input logic [IDX_W-1:0]  x,
      input logic [IDX_W-1:0]  xstep,
      input logic [IDX_W-1:0]  y,
      input logic [IDX_W-1:0]  ystep);
    logic [WORD_W-1:0] sx, sy, ux, uy;
    sx = {{(WORD_W-IDX_W){xstep[IDX_W-1]}}, xstep};
    sy = {{(WORD_W-IDX_W){ystep[IDX_W-1]}}, ystep};
    ux = {{(WORD_W-IDX_W){1'b0}}, x};
    uy = {{(WORD_W-IDX_W){1'b0}}, y};
    return base + sx * ux + sy * uy;
  endfunction

  function automatic logic [WORD_W-1:0] elem_mask(input logic [1:0] esize);
    case (esize)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [1:0] access_size(input logic [1:0] esize, input logic wide);
    return wide ? 2'd2 : esize;
  endfunction

endpackage

// File: rtl/dma_desc_store.sv
module dma_desc_store #(
  parameter int DEPTH = 32,
  parameter int WIN   = 6,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [PW-1:0]        wr_idx,
  input  logic [31:0]          wr_data,
  input  logic [PW-1:0]        rd_ptr,
  output logic [WIN-1:0][31:0] win
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // consecutive words starting at rd_ptr, wrapping at the store size
  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic [PW-1:0] idx;
    assign idx    = rd_ptr + PW'(k);
    assign win[k] = mem[idx];
  end
endmodule

// File: rtl/dma_desc_decode.sv
module dma_desc_decode
  import dma_seq_pkg::*;
(
  input  logic [DESC_WORDS-1:0][WORD_W-1:0] win,
  output desc_t                             desc,
  output logic                              bad
);
  logic [WORD_W-1:0] ctl, xw, yw, nxt;
  desc_kind_e        kind;
  logic              unused_bits;

  assign ctl  = win[0];
  assign kind = desc_kind_e'(ctl[31:30]);

  always_comb begin
    xw  = '0;
    yw  = '0;
    nxt = '0;
    case (kind)
      DK_SINGLE: nxt = win[3];
      DK_ROW:    begin xw = win[3]; nxt = win[4]; end
      DK_GRID:   begin xw = win[3]; yw = win[4]; nxt = win[5]; end
      default:   nxt = '0;
    endcase
  end

  assign bad = (kind == DK_BAD) || (ctl[29:28] == 2'd3);

  always_comb begin
    desc            = '0;
    desc.esize      = ctl[29:28];
    desc.dst_wide   = ctl[27];
    desc.src_wide   = ctl[26];
    desc.stop_after = ctl[24];
    desc.tmode      = trig_mode_e'(ctl[21:20]);
    desc.src_base   = win[1];
    desc.dst_base   = win[2];
    desc.xlast      = xw[7:0];
    desc.sxstep     = xw[15:8];
    desc.dxstep     = xw[23:16];
    desc.ylast      = yw[7:0];
    desc.systep     = yw[15:8];
    desc.dystep     = yw[23:16];
    desc.next_ptr   = nxt;
  end

  assign unused_bits = ^{ctl[25], ctl[23:22], ctl[19:0], xw[31:24], yw[31:24]};
endmodule

// File: rtl/dma_elem_path.sv
module dma_elem_path
  import dma_seq_pkg::*;
(
  input  logic [1:0]        esize,
  input  logic              src_wide,
  input  logic              dst_wide,
  input  logic [WORD_W-1:0] rd_data,
  output logic [1:0]        rd_size,
  output logic [1:0]        wr_size,
  output logic [WORD_W-1:0] wr_data
);
  assign rd_size = access_size(esize, src_wide);
  assign wr_size = access_size(esize, dst_wide);
  // bits above the element are dropped on read and zero on write
  assign wr_data = rd_data & elem_mask(esize);
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dma_seq_pkg::*;
#(
  parameter int DESC_DEPTH = 32,
  localparam int PTR_W     = $clog2(DESC_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [PTR_W-1:0]  cfg_wr_idx,
  input  logic [31:0]       cfg_wr_data,
  input  logic              ch_start,
  input  logic [PTR_W-1:0]  ch_start_ptr,
  input  logic              trig_in,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  output logic [1:0]        rd_size,
  input  logic [31:0]       rd_data,
  output logic              wr_req,
  output logic [31:0]       wr_addr,
  output logic [1:0]        wr_size,
  output logic [31:0]       wr_data,
  output logic              ch_en,
  output logic              busy,
  output logic              desc_done,
  output logic              err
);
  seq_state_e       state;
  logic             ch_en_q, err_q, pend_q, loaded_q;
  logic [PTR_W-1:0] cur_ptr;
  desc_t            desc_q, dec;
  logic             dec_bad;
  logic [IDX_W-1:0] xi, yi;
  logic [DESC_WORDS-1:0][WORD_W-1:0] win;

  // named events
  logic accept, start_ok, last_x, last_y, desc_end, unit_end, chain_stop, late_trig;

  dma_desc_store #(.DEPTH(DESC_DEPTH), .WIN(DESC_WORDS)) u_store (
    .clk(clk), .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
    .rd_ptr(cur_ptr), .win(win)
  );

  dma_desc_decode u_dec (.win(win), .desc(dec), .bad(dec_bad));

  dma_elem_path u_path (
    .esize(desc_q.esize), .src_wide(desc_q.src_wide), .dst_wide(desc_q.dst_wide),
    .rd_data(rd_data), .rd_size(rd_size), .wr_size(wr_size), .wr_data(wr_data)
  );

  assign start_ok   = (state == S_IDLE) && ch_start;
  assign accept     = (state == S_IDLE) && ch_en_q && !ch_start && (trig_in || pend_q);
  assign late_trig  = (state != S_IDLE) && ch_en_q && trig_in;
  assign last_x     = (xi == desc_q.xlast);
  assign last_y     = (yi == desc_q.ylast);
  assign desc_end   = last_x && last_y;
  assign chain_stop = desc_q.stop_after || (desc_q.next_ptr == '0);

  always_comb begin
    case (desc_q.tmode)
      TM_ELEM: unit_end = 1'b1;
      TM_ROW:  unit_end = last_x;
      default: unit_end = desc_end;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ch_en_q  <= 1'b0;
      err_q    <= 1'b0;
      pend_q   <= 1'b0;
      loaded_q <= 1'b0;
      cur_ptr  <= '0;
      desc_q   <= '0;
      xi       <= '0;
      yi       <= '0;
    end else begin
      if (late_trig) pend_q <= 1'b1;
      case (state)
        S_IDLE: begin
          if (start_ok) begin
            ch_en_q  <= 1'b1;
            err_q    <= 1'b0;
            pend_q   <= 1'b0;
            loaded_q <= 1'b0;
            cur_ptr  <= ch_start_ptr;
          end else if (accept) begin
            pend_q <= pend_q & trig_in;
            state  <= loaded_q ? S_RD : S_LOAD;
          end
        end
        S_LOAD: begin
          if (dec_bad) begin
            err_q   <= 1'b1;
            ch_en_q <= 1'b0;
            pend_q  <= 1'b0;
            state   <= S_IDLE;
          end else begin
            desc_q   <= dec;
            loaded_q <= 1'b1;
            xi       <= '0;
            yi       <= '0;
            state    <= S_RD;
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          if (last_x) begin
            xi <= '0;
            if (!last_y) yi <= yi + 1'b1;
          end else begin
            xi <= xi + 1'b1;
          end
          if (desc_end)      state <= S_DONE;
          else if (unit_end) state <= S_IDLE;
          else               state <= S_RD;
        end
        S_DONE: begin
          loaded_q <= 1'b0;
          if (chain_stop) begin
            ch_en_q <= 1'b0;
            pend_q  <= 1'b0;
            state   <= S_IDLE;
          end else begin
            cur_ptr <= desc_q.next_ptr[PTR_W-1:0];
            state   <= (desc_q.tmode == TM_CHAIN) ? S_LOAD : S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_req    = (state == S_RD);
  assign wr_req    = (state == S_WR);
  assign rd_addr   = elem_addr(desc_q.src_base, xi, desc_q.sxstep, yi, desc_q.systep);
  assign wr_addr   = elem_addr(desc_q.dst_base, xi, desc_q.dxstep, yi, desc_q.dystep);
  assign ch_en     = ch_en_q;
  assign busy      = (state != S_IDLE);
  assign desc_done = (state == S_DONE);
  assign err       = err_q;

  AST_EN_ONLY_BY_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(ch_en) |-> $past(ch_start)); // R1
  AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!ch_en && !ch_start) |=> !busy); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) wr_req |-> $past(rd_req)); // R8
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_req && wr_req)); // R8
  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (wr_req && desc_q.esize == 2'd0) |-> (wr_data[31:8] == 24'h0)); // R9
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> !ch_en); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) desc_done |=> !desc_done); // R11
  AST_OFF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !ch_en |-> !busy); // R12
endmodule

// File: tb/dma_desc_seq_bench.sv
module dma_desc_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_en = 1'b0, ch_start = 1'b0, trig_in = 1'b0;
  logic [PW-1:0] cfg_wr_idx = '0, ch_start_ptr = '0;
  logic [31:0] cfg_wr_data = '0, rd_data = '0;
  logic rd_req, wr_req, ch_en, busy, desc_done, err;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [1:0] rd_size, wr_size;

  int n_tests = 0, n_fail = 0;
  int wcnt = 0, rcnt = 0, done_cnt = 0;
  logic [31:0] wl_addr [64];
  logic [31:0] wl_data [64];
  logic [1:0]  wl_size [64];
  logic [1:0]  rl_size [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_seq #(.DESC_DEPTH(32)) u_dma_desc_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .ch_start(ch_start), .ch_start_ptr(ch_start_ptr),
    .trig_in(trig_in), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .ch_en(ch_en), .busy(busy), .desc_done(desc_done), .err(err)
  );

  function automatic logic [31:0] src_word(input logic [31:0] a);
    return (a * 32'h0101_0101) ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [31:0] keep_bits(input int es);
    logic [63:0] one = 64'd1;
    return 32'((one << (8 << es)) - 64'd1);
  endfunction

  function automatic logic [31:0] mk_ctl(input int kind, input int es, input bit dw,
                                         input bit sw, input bit stop, input int tm);
    return (32'(kind) << 30) | (32'(es) << 28) | (32'(dw) << 27) | (32'(sw) << 26)
         | (32'(stop) << 24) | (32'(tm) << 20);
  endfunction

  function automatic logic [31:0] mk_step(input int last, input int s, input int d);
    return (32'(d & 255) << 16) | (32'(s & 255) << 8) | 32'(last);
  endfunction

  function automatic logic [31:0] exp_addr(input int base, input int x, input int sx,
                                           input int y, input int sy);
    return 32'(base + x * sx + y * sy);
  endfunction

  // bus model: data for a read appears on the cycle after the request
  always @(negedge clk) begin
    if (rd_req) begin
      rd_data <= src_word(rd_addr);
      if (rcnt < 64) rl_size[rcnt] = rd_size;
      rcnt++;
    end
    if (wr_req) begin
      if (wcnt < 64) begin
        wl_addr[wcnt] = wr_addr; wl_data[wcnt] = wr_data; wl_size[wcnt] = wr_size;
      end
      wcnt++;
    end
    if (desc_done) done_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_idx = PW'(idx); cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic start(input int p);
    @(negedge clk); ch_start = 1'b1; ch_start_ptr = PW'(p);
    @(negedge clk); ch_start = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic clear_log();
    @(negedge clk); wcnt = 0; rcnt = 0; done_cnt = 0;
  endtask

  task automatic load_row_elem();
    put(4, mk_ctl(1, 2, 0, 0, 0, 0));
    put(5, 32'h200); put(6, 32'h400);
    put(7, mk_step(3, 4, -2));
    put(8, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset ch_en", {31'b0, ch_en}, 0);
    check("reset busy R12", {31'b0, busy}, 0);
    check("reset err", {31'b0, err}, 0);
    check("reset bus", {30'b0, rd_req, wr_req}, 0);

    // R2: triggers while disabled do nothing and are forgotten
    load_row_elem();
    clear_log();
    pulse_trig(); repeat (8) @(negedge clk);
    check("R2 no work while off", wcnt, 0);
    check("R2 not busy while off", {31'b0, busy}, 0);
    start(4);
    check("R1 enabled", {31'b0, ch_en}, 1);
    check("R1 err clear", {31'b0, err}, 0);
    repeat (6) @(negedge clk);
    check("R2 trigger not remembered", wcnt, 0);

    // R3, R8: one element per trigger, signed steps
    for (int k = 0; k < 4; k++) begin
      pulse_trig(); settle();
      check("R3 one element per trigger", wcnt, k + 1);
      check("R8 dst addr", wl_addr[k], exp_addr(32'h400, k, -2, 0, 0));
      check("R8 data", wl_data[k], src_word(exp_addr(32'h200, k, 4, 0, 0)));
    end
    check("R11 done once", done_cnt, 1);
    check("R11 zero next disables", {31'b0, ch_en}, 0);

    // R9, R11: size sweep on single descriptors with stop bit and valid next
    for (int es = 0; es < 3; es++)
      for (int dw = 0; dw < 2; dw++)
        for (int sw = 0; sw < 2; sw++) begin
          int src = 32'h1000 + 16 * (es * 4 + dw * 2 + sw) + 3;
          int dst = 32'h8000 + 4 * (es * 4 + dw * 2 + sw);
          put(0, mk_ctl(0, es, dw[0], sw[0], 1, 2));
          put(1, 32'(src)); put(2, 32'(dst)); put(3, 32'd12);
          start(0); clear_log();
          pulse_trig(); settle();
          check("R9 one write", wcnt, 1);
          check("R9 write addr", wl_addr[0], 32'(dst));
          check("R9 narrowed data", wl_data[0], src_word(32'(src)) & keep_bits(es));
          check("R9 wr size", {30'b0, wl_size[0]}, dw ? 2 : es);
          check("R9 rd size", {30'b0, rl_size[0]}, sw ? 2 : es);
          check("R11 stop bit disables", {31'b0, ch_en}, 0);
          check("R11 done pulse", done_cnt, 1);
        end

    // R4, R8, R12: grid kind, one row per trigger
    put(10, mk_ctl(2, 1, 1, 0, 0, 1));
    put(11, 32'h3000); put(12, 32'h5000);
    put(13, mk_step(2, 2, 4));
    put(14, mk_step(1, 32, -128));
    put(15, 32'h0);
    start(10); clear_log();
    pulse_trig();
    check("R12 busy after trigger", {31'b0, busy}, 1);
    settle();
    check("R12 idle after row", {31'b0, busy}, 0);
    check("R4 row length", wcnt, 3);
    pulse_trig(); settle();
    check("R4 second row", wcnt, 6);
    for (int i = 0; i < 6; i++) begin
      check("R8 grid dst", wl_addr[i], exp_addr(32'h5000, i % 3, 4, i / 3, -128));
      check("R9 grid data", wl_data[i],
            src_word(exp_addr(32'h3000, i % 3, 2, i / 3, 32)) & 32'hFFFF);
    end
    check("R11 grid done", done_cnt, 1);

    // R4: row mode on single kind moves one element
    put(16, mk_ctl(0, 2, 0, 0, 0, 1));
    put(17, 32'h40); put(18, 32'h80); put(19, 32'h0);
    start(16); clear_log();
    pulse_trig(); settle();
    check("R4 single kind one element", wcnt, 1);

    // R5, R6: chain of a row descriptor then a single descriptor
    put(20, mk_ctl(1, 0, 0, 1, 0, 3));
    put(21, 32'h100); put(22, 32'h700);
    put(23, mk_step(1, 1, 1)); put(24, 32'd26);
    put(26, mk_ctl(0, 1, 1, 1, 0, 2));
    put(27, 32'h900); put(28, 32'hA00); put(29, 32'h0);
    start(20); clear_log();
    pulse_trig(); settle();
    check("R6 chain total", wcnt, 3);
    check("R6 both done", done_cnt, 2);
    check("R5 chained dst", wl_addr[2], 32'hA00);
    check("R5 chained data", wl_data[2], src_word(32'h900) & 32'hFFFF);
    check("R11 chain end disables", {31'b0, ch_en}, 0);

    // R7: trigger held over busy cycles adds one unit only
    load_row_elem();
    start(4); clear_log();
    @(negedge clk); trig_in = 1'b1;
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
    settle();
    check("R7 held trigger one extra", wcnt, 2);

    // R7: trigger in the very cycle the element write ends
    start(4); clear_log();
    pulse_trig();
    while (!wr_req) @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    settle();
    check("R7 coincident trigger kept", wcnt, 2);
    check("R7 next address", wl_addr[1], exp_addr(32'h400, 1, -2, 0, 0));

    // R10: bad element size, then bad kind
    put(28, mk_ctl(0, 3, 0, 0, 0, 2));
    put(29, 32'h10); put(30, 32'h20); put(31, 32'h0);
    start(28); clear_log();
    pulse_trig(); settle();
    check("R10 err on size 3", {31'b0, err}, 1);
    check("R10 channel off", {31'b0, ch_en}, 0);
    check("R10 no access", wcnt + rcnt, 0);
    put(28, mk_ctl(3, 0, 0, 0, 0, 2));
    start(28);
    check("R1 start clears err", {31'b0, err}, 0);
    pulse_trig(); settle();
    check("R10 err on kind 3", {31'b0, err}, 1);
    check("R10 no access kind", wcnt + rcnt, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule